// File: doc/BRIEF.md
# Hall-Synchronized Soft-Ramp PWM Sequencer

This block produces the four gate-drive signals for an H-bridge that drives a single-phase brushless DC motor. It runs on a clock that an external loop keeps phase-locked to rotation. It takes the already squared and synchronized Hall level, a speed-qualified input and a drive-kill input. A free-running base counter sets the PWM period. The PWM high time is the part of the period in which the counter is below the current duty value. The Hall level decides which of the two high-side outputs carries the PWM.

Before speed is qualified, the high-side pair toggles as a fixed 50% complementary square wave, which gets the rotor turning. Once speed is qualified, every Hall transition, rising or falling, starts a fresh envelope. The duty starts at a programmed floor and climbs one step per ramp-up interval until it reaches a programmed ceiling, then holds. When the count of completed PWM periods since the edge reaches a programmed soft-stop point, the duty falls one step per ramp-down interval back to the floor and stays there until the next edge. After every Hall transition, both low-side gates are pulsed high for a fixed time so that regenerated current has a path.

Top module: `hall_ramp_pwm`

## Requirements
- R1: The PWM period is 2^CNT_W clocks. The base counter restarts at 0 in the clock after any Hall change is registered. While speed is qualified, the active high-side output is high exactly while the counter is below the current duty, so a period with a constant duty d shows d high clocks.
- R2: While `speed_ok` is low, `hs_a` follows the upper half of the base count (low for counts 0 to 2^(CNT_W-1)-1, then high) and `hs_b` is its complement, whatever the Hall level. The duty is held at `duty_min`, and raising `speed_ok` without a Hall edge leaves it at `duty_min`.
- R3: With `speed_ok` high, every Hall transition in either direction loads the duty with `duty_min`. The duty then rises by one step every `rate_up`+1 clocks. With `rate_up` = 2^CNT_W-1, PWM period j after the edge carries duty `duty_min`+j.
- R4: When the rising duty reaches `duty_max`, it stays there until the soft stop begins.
- R5: The soft stop begins at the PWM period boundary where the count of completed periods since the edge becomes at least `stop_at`. That count saturates at 2^PER_W-1. The first down step follows `rate_dn`+1 clocks later, and further steps follow at the same spacing until the duty reaches `duty_min`. The duty then holds there until the next Hall edge.
- R6: The ramp-down spacing comes only from `rate_dn` and the ramp-up spacing only from `rate_up`, so the two slopes differ when the two rates differ.
- R7: A `stop_at` value above 2^PER_W-1 acts as 2^PER_W-1, so the soft stop still begins in the last countable period.
- R8: With `speed_ok` high, a registered Hall level of 1 puts the PWM on `hs_a` and holds `hs_b` low. A level of 0 does the reverse. The two high-side outputs are never high together.
- R9: `ls_a` and `ls_b` are high together for exactly LS_CYCLES clocks, starting in the clock after a Hall change is registered, in both start-up and envelope operation.
- R10: While `kill` is high, all four outputs are low in the same cycle. A `kill` that covers a clock edge clears the low-side pulse and returns the duty to `duty_min`, where it stays until the next Hall edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rotation-locked clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 1 | Synchronized Hall square wave |
| speed_ok | input | 1 | Speed qualified; selects envelope operation over start-up square wave |
| kill | input | 1 | Forces all drives low and returns duty to the floor |
| duty_min | input | CNT_W | Duty floor (start and end of every envelope) |
| duty_max | input | CNT_W | Duty ceiling |
| rate_up | input | RATE_W | Ramp-up interval minus one, in clocks |
| rate_dn | input | RATE_W | Ramp-down interval minus one, in clocks |
| stop_at | input | PER_W+1 | Completed-period count after the edge at which soft stop begins |
| hs_a | output | 1 | High-side drive A |
| hs_b | output | 1 | High-side drive B |
| ls_a | output | 1 | Low-side gate A |
| ls_b | output | 1 | Low-side gate B |

## Verification
The bench builds the block with CNT_W = 4, PER_W = 4, RATE_W = 6 and LS_CYCLES = 10. This gives 16-clock PWM periods and saturates the period count at 15. A whole half-rotation, including saturation of the period count and clamping of an oversize soft-stop point, therefore fits in a few hundred clocks. With ramp rates of 15, every duty step lands on a period boundary, so the bench can count high clocks period by period and read the envelope from the outputs alone. A 10-clock low-side pulse ends inside the first period, so its exact length shows in a single period's count.

// File: rtl/hall_ramp_pkg.sv
package hall_ramp_pkg;

    // Phases of the per-half-rotation duty envelope
    typedef enum logic [1:0] {
        ENV_RISE    = 2'd0,
        ENV_CEIL    = 2'd1,
        ENV_FALL    = 2'd2,
        ENV_FLOOR   = 2'd3
    } env_phase_e;

    // Width needed to hold a down-counter loaded with n
    function automatic int span_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hrp_base.sv
module hrp_base #(
    parameter int CNT_W = 7,
    parameter int PER_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic [PER_W-1:0] per_nxt,
    output logic             boundary
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [PER_W-1:0] PER_TOP = '1;

    logic [PER_W-1:0] per;

    // A period closes when the counter wraps, unless an edge restarts it
    assign boundary = (cnt == CNT_TOP) && !restart;
    assign per_nxt  = (per == PER_TOP) ? per : per + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
            per <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (boundary)
                per <= per_nxt;
        end
    end
endmodule

// File: rtl/hrp_env.sv
module hrp_env
    import hall_ramp_pkg::*;
#(
    parameter int DUTY_W = 7,
    parameter int PER_W  = 7,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic              kill,
    input  logic              boundary,
    input  logic [PER_W-1:0]  per_nxt,
    input  logic [DUTY_W-1:0] duty_min,
    input  logic [DUTY_W-1:0] duty_max,
    input  logic [RATE_W-1:0] rate_up,
    input  logic [RATE_W-1:0] rate_dn,
    input  logic [PER_W:0]    stop_at,
    output logic [DUTY_W-1:0] duty
);
    localparam int          PER_MAX = (1 << PER_W) - 1;
    localparam logic [PER_W:0] PER_LIM = PER_MAX[PER_W:0];

    env_phase_e        phase;
    logic [RATE_W-1:0] presc;
    logic [PER_W-1:0]  stop_eff;
    logic              stop_hit;

    // Soft-stop point never lies beyond the last countable period
    assign stop_eff = (stop_at > PER_LIM) ? PER_LIM[PER_W-1:0] : stop_at[PER_W-1:0];
    assign stop_hit = boundary && (per_nxt >= stop_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ENV_FLOOR;
            duty  <= '0;
            presc <= '0;
        end else if (kill || !run) begin
            phase <= ENV_FLOOR;
            duty  <= duty_min;
            presc <= '0;
        end else if (restart) begin
            phase <= ENV_RISE;
            duty  <= duty_min;
            presc <= rate_up;
        end else begin
            unique case (phase)
                ENV_RISE, ENV_CEIL: begin
                    if (stop_hit) begin
                        phase <= ENV_FALL;
                        presc <= rate_dn;
                    end else if (phase == ENV_RISE) begin
                        if (duty >= duty_max) begin
                            phase <= ENV_CEIL;
                        end else if (presc == '0) begin
                            duty  <= duty + 1'b1;
                            presc <= rate_up;
                        end else begin
                            presc <= presc - 1'b1;
                        end
                    end
                end
                ENV_FALL: begin
                    if (duty <= duty_min) begin
                        phase <= ENV_FLOOR;
                    end else if (presc == '0) begin
                        duty  <= duty - 1'b1;
                        presc <= rate_dn;
                    end else begin
                        presc <= presc - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hrp_drive.sv
module hrp_drive
    import hall_ramp_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int LS_CYCLES = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             kill,
    input  logic             hall_lvl,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    output logic             hs_a,
    output logic             hs_b,
    output logic             ls_a,
    output logic             ls_b
);
    localparam int LS_W = span_bits(LS_CYCLES);
    localparam logic [LS_W-1:0] LS_LOAD = LS_CYCLES[LS_W-1:0];

    logic [LS_W-1:0] ls_left;
    logic            pwm;
    logic            half;
    logic            ls_on;

    assign pwm  = cnt < duty;
    assign half = cnt[CNT_W-1];

    always_ff @(posedge clk) begin
        if (rst || kill)
            ls_left <= '0;
        else if (restart)
            ls_left <= LS_LOAD;
        else if (ls_left != '0)
            ls_left <= ls_left - 1'b1;
    end

    assign ls_on = (ls_left != '0) && !kill;
    assign ls_a  = ls_on;
    assign ls_b  = ls_on;

    always_comb begin
        if (kill) begin
            hs_a = 1'b0;
            hs_b = 1'b0;
        end else if (!run) begin
            hs_a = half;
            hs_b = !half;
        end else begin
            hs_a = hall_lvl  && pwm;
            hs_b = !hall_lvl && pwm;
        end
    end
endmodule

// File: rtl/hall_ramp_pwm.sv
module hall_ramp_pwm
    import hall_ramp_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int PER_W     = 7,
    parameter int RATE_W    = 8,
    parameter int LS_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hall,
    input  logic              speed_ok,
    input  logic              kill,
    input  logic [CNT_W-1:0]  duty_min,
    input  logic [CNT_W-1:0]  duty_max,
    input  logic [RATE_W-1:0] rate_up,
    input  logic [RATE_W-1:0] rate_dn,
    input  logic [PER_W:0]    stop_at,
    output logic              hs_a,
    output logic              hs_b,
    output logic              ls_a,
    output logic              ls_b
);
    logic             hall_q;
    logic             hall_edge;
    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] per_nxt;
    logic             boundary;
    logic [CNT_W-1:0] duty;

    always_ff @(posedge clk) begin
        if (rst)
            hall_q <= 1'b0;
        else
            hall_q <= hall;
    end

    assign hall_edge = hall ^ hall_q;

    hrp_base #(.CNT_W(CNT_W), .PER_W(PER_W)) base_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (hall_edge),
        .cnt      (cnt),
        .per_nxt  (per_nxt),
        .boundary (boundary)
    );

    hrp_env #(.DUTY_W(CNT_W), .PER_W(PER_W), .RATE_W(RATE_W)) env_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (hall_edge),
        .run      (speed_ok),
        .kill     (kill),
        .boundary (boundary),
        .per_nxt  (per_nxt),
        .duty_min (duty_min),
        .duty_max (duty_max),
        .rate_up  (rate_up),
        .rate_dn  (rate_dn),
        .stop_at  (stop_at),
        .duty     (duty)
    );

    hrp_drive #(.CNT_W(CNT_W), .LS_CYCLES(LS_CYCLES)) drive_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (hall_edge),
        .run      (speed_ok),
        .kill     (kill),
        .hall_lvl (hall_q),
        .cnt      (cnt),
        .duty     (duty),
        .hs_a     (hs_a),
        .hs_b     (hs_b),
        .ls_a     (ls_a),
        .ls_b     (ls_b)
    );
endmodule

// File: rtl/hall_ramp_chk.sv
module hall_ramp_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             kill,
    input logic             speed_ok,
    input logic             hall_edge,
    input logic [CNT_W-1:0] duty,
    input logic             hs_a,
    input logic             hs_b,
    input logic             ls_a,
    input logic             ls_b
);
    assert_kill_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        kill |-> (!hs_a && !hs_b && !ls_a && !ls_b));

    assert_hs_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hs_a, hs_b}));

    assert_ls_pair_R9: assert property (@(posedge clk) disable iff (rst)
        ls_a == ls_b);

    assert_ls_from_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_a) |-> $past(hall_edge));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (speed_ok && !kill && !hall_edge) |=>
            (int'(duty) == int'($past(duty)) ||
             int'(duty) == int'($past(duty)) + 1 ||
             int'(duty) == int'($past(duty)) - 1));
endmodule

bind hall_ramp_pwm hall_ramp_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .kill      (kill),
    .speed_ok  (speed_ok),
    .hall_edge (hall_edge),
    .duty      (duty),
    .hs_a      (hs_a),
    .hs_b      (hs_b),
    .ls_a      (ls_a),
    .ls_b      (ls_b)
);

// File: tb/hall_ramp_pwm_tb_top.sv
module hall_ramp_pwm_tb_top;
    localparam int CNT_W  = 4;
    localparam int PER_W  = 4;
    localparam int RATE_W = 6;
    localparam int LS_CYC = 10;
    localparam int PLEN   = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hall = 1'b0;
    logic              speed_ok = 1'b0;
    logic              kill = 1'b0;
    logic [CNT_W-1:0]  duty_min = 4'd2;
    logic [CNT_W-1:0]  duty_max = 4'd6;
    logic [RATE_W-1:0] rate_up = 6'd15;
    logic [RATE_W-1:0] rate_dn = 6'd15;
    logic [PER_W:0]    stop_at = 5'd8;
    logic              hs_a, hs_b, ls_a, ls_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pa [0:31];
    int pb [0:31];
    int pl [0:31];

    always #5 clk = ~clk;

    hall_ramp_pwm #(.CNT_W(CNT_W), .PER_W(PER_W), .RATE_W(RATE_W), .LS_CYCLES(LS_CYC)) dut_i (
        .clk(clk), .rst(rst), .hall(hall), .speed_ok(speed_ok), .kill(kill),
        .duty_min(duty_min), .duty_max(duty_max), .rate_up(rate_up), .rate_dn(rate_dn),
        .stop_at(stop_at), .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Counts high clocks over PWM periods; called right after a Hall toggle at a negedge
    task automatic run_periods(input int n);
        for (int p = 0; p < n; p++) begin
            pa[p] = 0; pb[p] = 0; pl[p] = 0;
            for (int c = 0; c < PLEN; c++) begin
                @(negedge clk);
                pa[p] += int'(hs_a);
                pb[p] += int'(hs_b);
                pl[p] += int'(ls_a);
            end
        end
    endtask

    task automatic t_reset();
        chk("R2", "reset hs_a", int'(hs_a), 0);
        chk("R2", "reset hs_b", int'(hs_b), 1);
        chk("R9", "reset ls_a", int'(ls_a), 0);
        chk("R9", "reset ls_b", int'(ls_b), 0);
    endtask

    task automatic t_startup();
        hall = 1'b1;
        run_periods(2);
        chk("R2", "startup hs_a high clocks", pa[0], PLEN / 2);
        chk("R2", "startup hs_b high clocks", pb[0], PLEN / 2);
        chk("R9", "startup ls pulse length", pl[0], LS_CYC);
        chk("R9", "ls quiet in second period", pl[1], 0);
    endtask

    task automatic t_envelope();
        speed_ok = 1'b1;
        run_periods(1);
        chk("R2", "no ramp without edge", pa[0], 2);
        hall = 1'b0;
        run_periods(16);
        chk("R8", "hs_a idle at hall low", pa[0], 0);
        chk("R1", "period 0 duty", pb[0], 2);
        chk("R3", "period 1 duty", pb[1], 3);
        chk("R3", "period 3 duty", pb[3], 5);
        chk("R4", "period 4 at ceiling", pb[4], 6);
        chk("R4", "period 7 held", pb[7], 6);
        chk("R5", "period 8 stop starts", pb[8], 6);
        chk("R5", "period 9 falling", pb[9], 5);
        chk("R5", "period 12 at floor", pb[12], 2);
        chk("R5", "period 15 held at floor", pb[15], 2);
    endtask

    task automatic t_slow_fall();
        rate_dn = 6'd31;
        hall = 1'b1;
        run_periods(13);
        chk("R8", "hs_b idle at hall high", pb[0], 0);
        chk("R3", "hs_a period 2 duty", pa[2], 4);
        chk("R6", "period 9 still at ceiling", pa[9], 6);
        chk("R6", "period 10 first step", pa[10], 5);
        chk("R6", "period 11 unchanged", pa[11], 5);
        chk("R6", "period 12 second step", pa[12], 4);
    endtask

    task automatic t_clamp();
        rate_dn = 6'd15;
        stop_at = 5'd31;
        hall = 1'b0;
        run_periods(18);
        chk("R7", "period 14 at ceiling", pb[14], 6);
        chk("R7", "period 15 stop starts", pb[15], 6);
        chk("R7", "period 16 falling", pb[16], 5);
        chk("R7", "period 17 falling", pb[17], 4);
    endtask

    task automatic t_kill();
        stop_at = 5'd8;
        hall = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "hs_a before kill", int'(hs_a), 1);
        chk("R10", "ls_a before kill", int'(ls_a), 1);
        kill = 1'b1;
        #1;
        chk("R10", "drives under kill", int'({hs_a, hs_b, ls_a, ls_b}), 0);
        @(negedge clk);
        kill = 1'b0;
        @(negedge clk);
        chk("R10", "ls pulse cleared", int'({ls_a, ls_b}), 0);
        repeat (12) @(negedge clk);
        run_periods(1);
        chk("R10", "period 1 at floor", pa[0], 2);
        repeat (48) @(negedge clk);
        run_periods(1);
        chk("R10", "period 5 at floor", pa[0], 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_startup();
        t_envelope();
        t_slow_fall();
        t_clamp();
        t_kill();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule